// File: doc/BRIEF.md
# Memory Access ASI and Byte-Order Unit

This block sits between instruction decode and the load/store pipe of a processor core. For every memory access it decides which address-space identifier (ASI) the access carries and whether that ASI implies little-endian byte order. Instruction fetches and ordinary data accesses get an implicit ASI that depends on the trap level and the current little-endian mode bit. Alternate-space accesses take their ASI from the instruction or from the ASI register.

The block also flags a privileged-action fault when nonprivileged code names a restricted ASI. For alternate-space prefetches, a parameter chooses whether that case faults or is quietly turned into a no-op.

Store data going out and load data coming back both pass through a byte-reversal path sized by the access width. Little-endian doubleword pair accesses reverse each 32-bit word on its own, so each word lands in its own even or odd register or memory word. All results are registered one cycle after an input strobe.

Top module: `asi_sel_swap`

## Requirements
- R1: An instruction fetch (kind code 0) uses the primary ASI (0x80) at trap level 0 and the nucleus ASI (0x04) at any higher trap level. Its little-endian flag is 0 and both data paths pass unchanged.
- R2: A normal data access (kind code 1) at trap level 0 uses ASI 0x80 when the little-endian mode bit is 0 and ASI 0x88 when it is 1. The little-endian flag equals the mode bit.
- R3: A normal data access above trap level 0 uses ASI 0x04 when the little-endian mode bit is 0 and ASI 0x0C when it is 1. The little-endian flag equals the mode bit.
- R4: An alternate-space access (kind code 2, or code 3 for prefetch) takes its ASI from the immediate field when the immediate-select bit is 0 and from the ASI register when it is 1. The little-endian flag is bit 3 of the chosen ASI.
- R5: An alternate-space access of kind code 2 with the privilege bit at 0 and an ASI below 0x80 raises the fault output. An ASI at or above 0x80, a privileged access, and any fetch or normal access never raise the fault.
- R6: With the default setting of the prefetch parameter (no-op), a prefetch-alternate access (kind code 3) that meets the same restricted-ASI condition raises the no-op output instead of the fault output.
- R7: When the little-endian flag is 1, the low bytes of the data are reversed over the access size. Size codes are 0 for byte (unchanged), 1 for halfword (2 bytes), 2 for word (4 bytes) and 3 for extended word (8 bytes). Bytes above the access size pass unchanged. When the flag is 0, data passes unchanged. Store and load paths behave alike.
- R8: Size code 4 (doubleword pair) with the little-endian flag set reverses bytes 0..3 and bytes 4..7 each within their own 32-bit word. No byte crosses between the two words.
- R9: Outputs update on the clock edge after an input strobe, with the output-valid signal high for exactly those cycles. With no strobe, output-valid is low.
- R10: During reset, output-valid, fault and no-op are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_vld | input | 1 | Access strobe |
| i_kind | input | 2 | 0 fetch, 1 normal data, 2 alternate, 3 prefetch-alternate |
| i_size | input | 3 | 0 byte, 1 half, 2 word, 3 extended, 4 doubleword pair |
| i_tl | input | TL_W (3) | Current trap level |
| i_cle | input | 1 | Current little-endian mode bit |
| i_priv | input | 1 | Privileged mode |
| i_imm_sel | input | 1 | 1 selects the ASI register for alternate accesses |
| i_imm_asi | input | ASI_W (8) | ASI field of the instruction |
| i_asi_reg | input | ASI_W (8) | ASI register value |
| i_st_data | input | 64 | Store data from the register file |
| i_ld_data | input | 64 | Raw load data from memory |
| o_vld | output | 1 | Result valid |
| o_asi | output | ASI_W (8) | Chosen ASI |
| o_le | output | 1 | Effective little-endian flag |
| o_fault | output | 1 | Privileged-action fault |
| o_nop | output | 1 | Restricted prefetch turned into no-op |
| o_st_data | output | 64 | Byte-ordered store data |
| o_ld_data | output | 64 | Byte-ordered load data |

## Verification
Fetches and normal data accesses are driven across trap levels 0, 1 and 2 with the mode bit both clear and set. These patterns separate the four implicit ASIs and show that fetches ignore the mode bit. Alternate accesses take their ASI from both sources. The chosen ASIs sit just below, at, and above 0x80, with and without privilege, which pins the fault boundary and the prefetch no-op path.

Data patterns with a distinct value in every byte are sent at every size in both orders. A mix-up of the reversal span, or any byte crossing between the two words of a pair access, then shows up at once.

// File: rtl/asi_unit_pkg.sv
package asi_unit_pkg;

  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    AK_FETCH = 2'd0,
    AK_DATA  = 2'd1,
    AK_ALT   = 2'd2,
    AK_PFALT = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_XWORD = 3'd3,
    SZ_PAIR  = 3'd4
  } acc_size_e;

  // Reverse byte order over the access span; a pair reverses each word alone.
  function automatic logic [DATA_W-1:0] order_bytes(input logic [DATA_W-1:0] d,
                                                    input logic [2:0] sz);
    logic [DATA_W-1:0] r;
    r = d;
    case (sz)
      SZ_HALF: r[15:0] = {d[7:0], d[15:8]};
      SZ_WORD: for (int b = 0; b < 4; b++) r[8*b +: 8] = d[8*(3-b) +: 8];
      SZ_XWORD: for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
      SZ_PAIR: for (int b = 0; b < 4; b++) begin
        r[8*b +: 8]      = d[8*(3-b) +: 8];
        r[32 + 8*b +: 8] = d[32 + 8*(3-b) +: 8];
      end
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/asi_pick.sv
module asi_pick
  import asi_unit_pkg::*;
#(
  parameter int              ASI_W       = 8,
  parameter int              TL_W        = 3,
  parameter int              LE_BIT      = 3,
  parameter logic [ASI_W-1:0] PRIV_LIMIT = 'h80,
  parameter logic [ASI_W-1:0] ASI_PRI    = 'h80,
  parameter logic [ASI_W-1:0] ASI_PRI_LE = 'h88,
  parameter logic [ASI_W-1:0] ASI_NUC    = 'h04,
  parameter logic [ASI_W-1:0] ASI_NUC_LE = 'h0C,
  parameter bit              PREF_AS_NOP = 1'b1
) (
  input  acc_kind_e        kind,
  input  logic [TL_W-1:0]  tl,
  input  logic             cle,
  input  logic             priv,
  input  logic             imm_sel,
  input  logic [ASI_W-1:0] imm_asi,
  input  logic [ASI_W-1:0] asi_reg,
  output logic [ASI_W-1:0] asi,
  output logic             le,
  output logic             fault,
  output logic             nop,
  output logic             implicit_sel,
  output logic             priv_viol
);

  logic             at_tl0;
  logic             is_alt;
  logic [ASI_W-1:0] alt_asi;

  assign at_tl0       = (tl == '0);
  assign is_alt       = (kind == AK_ALT) || (kind == AK_PFALT);
  assign implicit_sel = !is_alt;
  assign alt_asi      = imm_sel ? asi_reg : imm_asi;

  always_comb begin
    asi = alt_asi;
    le  = alt_asi[LE_BIT];
    case (kind)
      AK_FETCH: begin
        asi = at_tl0 ? ASI_PRI : ASI_NUC;
        le  = 1'b0;
      end
      AK_DATA: begin
        if (at_tl0) asi = cle ? ASI_PRI_LE : ASI_PRI;
        else        asi = cle ? ASI_NUC_LE : ASI_NUC;
        le = cle;
      end
      default: ;
    endcase
  end

  assign priv_viol = is_alt && !priv && (alt_asi < PRIV_LIMIT);

  generate
    if (PREF_AS_NOP) begin : g_pf_nop
      assign fault = priv_viol && (kind != AK_PFALT);
      assign nop   = priv_viol && (kind == AK_PFALT);
    end else begin : g_pf_fault
      assign fault = priv_viol;
      assign nop   = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/byte_order.sv
module byte_order
  import asi_unit_pkg::*;
(
  input  logic              le,
  input  logic [2:0]        sz,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  assign dout = le ? order_bytes(din, sz) : din;

endmodule

// File: rtl/asi_sel_swap.sv
module asi_sel_swap
  import asi_unit_pkg::*;
#(
  parameter int              ASI_W       = 8,
  parameter int              TL_W        = 3,
  parameter int              LE_BIT      = 3,
  parameter logic [ASI_W-1:0] PRIV_LIMIT = 'h80,
  parameter logic [ASI_W-1:0] ASI_PRI    = 'h80,
  parameter logic [ASI_W-1:0] ASI_PRI_LE = 'h88,
  parameter logic [ASI_W-1:0] ASI_NUC    = 'h04,
  parameter logic [ASI_W-1:0] ASI_NUC_LE = 'h0C,
  parameter bit              PREF_AS_NOP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_vld,
  input  logic [1:0]        i_kind,
  input  logic [2:0]        i_size,
  input  logic [TL_W-1:0]   i_tl,
  input  logic              i_cle,
  input  logic              i_priv,
  input  logic              i_imm_sel,
  input  logic [ASI_W-1:0]  i_imm_asi,
  input  logic [ASI_W-1:0]  i_asi_reg,
  input  logic [DATA_W-1:0] i_st_data,
  input  logic [DATA_W-1:0] i_ld_data,
  output logic              o_vld,
  output logic [ASI_W-1:0]  o_asi,
  output logic              o_le,
  output logic              o_fault,
  output logic              o_nop,
  output logic [DATA_W-1:0] o_st_data,
  output logic [DATA_W-1:0] o_ld_data
);

  logic [ASI_W-1:0]  nx_asi;
  logic              nx_le;
  logic              nx_fault;
  logic              nx_nop;
  logic              implicit_sel;
  logic              priv_viol;
  logic [DATA_W-1:0] nx_st;
  logic [DATA_W-1:0] nx_ld;

  asi_pick #(
    .ASI_W(ASI_W), .TL_W(TL_W), .LE_BIT(LE_BIT), .PRIV_LIMIT(PRIV_LIMIT),
    .ASI_PRI(ASI_PRI), .ASI_PRI_LE(ASI_PRI_LE), .ASI_NUC(ASI_NUC),
    .ASI_NUC_LE(ASI_NUC_LE), .PREF_AS_NOP(PREF_AS_NOP)
  ) u_pick (
    .kind(acc_kind_e'(i_kind)), .tl(i_tl), .cle(i_cle), .priv(i_priv),
    .imm_sel(i_imm_sel), .imm_asi(i_imm_asi), .asi_reg(i_asi_reg),
    .asi(nx_asi), .le(nx_le), .fault(nx_fault), .nop(nx_nop),
    .implicit_sel(implicit_sel), .priv_viol(priv_viol)
  );

  byte_order u_st_order (.le(nx_le), .sz(i_size), .din(i_st_data), .dout(nx_st));
  byte_order u_ld_order (.le(nx_le), .sz(i_size), .din(i_ld_data), .dout(nx_ld));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld     <= 1'b0;
      o_asi     <= '0;
      o_le      <= 1'b0;
      o_fault   <= 1'b0;
      o_nop     <= 1'b0;
      o_st_data <= '0;
      o_ld_data <= '0;
    end else begin
      o_vld <= i_vld;
      if (i_vld) begin
        o_asi     <= nx_asi;
        o_le      <= nx_le;
        o_fault   <= nx_fault;
        o_nop     <= nx_nop;
        o_st_data <= nx_st;
        o_ld_data <= nx_ld;
      end
    end
  end

endmodule

// File: rtl/asi_sel_swap_chk.sv
module asi_sel_swap_chk #(
  parameter int              ASI_W      = 8,
  parameter int              TL_W       = 3,
  parameter logic [ASI_W-1:0] PRIV_LIMIT = 'h80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_vld,
  input logic [1:0]       i_kind,
  input logic [2:0]       i_size,
  input logic [TL_W-1:0]  i_tl,
  input logic             i_cle,
  input logic             i_priv,
  input logic             i_imm_sel,
  input logic [ASI_W-1:0] i_asi_reg,
  input logic [63:0]      i_st_data,
  input logic             implicit_sel,
  input logic             priv_viol,
  input logic             o_vld,
  input logic [ASI_W-1:0] o_asi,
  input logic             o_le,
  input logic             o_fault,
  input logic             o_nop,
  input logic [63:0]      o_st_data
);

  a_r1_fetch_big: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && $past(i_kind) == 2'd0) |-> !o_le);

  a_r2_data_tl0_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && $past(i_kind) == 2'd1 && $past(i_tl) == '0) |-> (o_le == $past(i_cle)));

  a_r4_alt_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && $past(i_kind) == 2'd2 && $past(i_imm_sel)) |-> (o_asi == $past(i_asi_reg)));

  a_r5_priv_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && $past(i_priv)) |-> !o_fault);

  a_r5_restricted_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && i_kind == 2'd2 && !i_priv && !implicit_sel && priv_viol) |=> o_fault);

  a_r5_implicit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && $past(implicit_sel)) |-> !(o_fault || o_nop));

  a_r6_nop_only_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    o_nop |-> ($past(i_kind) == 2'd3 && !$past(i_priv) && o_asi < PRIV_LIMIT));

  a_r8_pair_words_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && o_le && $past(i_size) == 3'd4) |->
      (o_st_data[7:0] == $past(i_st_data[31:24]) &&
       o_st_data[39:32] == $past(i_st_data[63:56])));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (o_vld == $past(i_vld)));

endmodule

bind asi_sel_swap asi_sel_swap_chk #(
  .ASI_W(ASI_W), .TL_W(TL_W), .PRIV_LIMIT(PRIV_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_kind(i_kind), .i_size(i_size),
  .i_tl(i_tl), .i_cle(i_cle), .i_priv(i_priv), .i_imm_sel(i_imm_sel),
  .i_asi_reg(i_asi_reg), .i_st_data(i_st_data), .implicit_sel(implicit_sel),
  .priv_viol(priv_viol), .o_vld(o_vld), .o_asi(o_asi), .o_le(o_le),
  .o_fault(o_fault), .o_nop(o_nop), .o_st_data(o_st_data)
);

// File: tb/asi_sel_swap_bench.sv
module asi_sel_swap_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_vld = 1'b0;
  logic [1:0]  i_kind = '0;
  logic [2:0]  i_size = '0;
  logic [2:0]  i_tl = '0;
  logic        i_cle = 1'b0, i_priv = 1'b0, i_imm_sel = 1'b0;
  logic [7:0]  i_imm_asi = '0, i_asi_reg = '0;
  logic [63:0] i_st_data = '0, i_ld_data = '0;
  logic        o_vld, o_le, o_fault, o_nop;
  logic [7:0]  o_asi;
  logic [63:0] o_st_data, o_ld_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [7:0]  asi;
    logic        le;
    logic        fault;
    logic        nop;
    logic [63:0] st;
    logic [63:0] ld;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  asi_sel_swap u_asi_sel_swap (
    .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_kind(i_kind), .i_size(i_size),
    .i_tl(i_tl), .i_cle(i_cle), .i_priv(i_priv), .i_imm_sel(i_imm_sel),
    .i_imm_asi(i_imm_asi), .i_asi_reg(i_asi_reg), .i_st_data(i_st_data),
    .i_ld_data(i_ld_data), .o_vld(o_vld), .o_asi(o_asi), .o_le(o_le),
    .o_fault(o_fault), .o_nop(o_nop), .o_st_data(o_st_data), .o_ld_data(o_ld_data)
  );

  // Mirror bytes lo..lo+n-1 of d.
  function automatic logic [63:0] mirror(input logic [63:0] d, input int lo, input int n);
    logic [63:0] r = d;
    for (int k = 0; k < n; k++) r[8*(lo+k) +: 8] = d[8*(lo+n-1-k) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] model_data(input logic [63:0] d, input logic le,
                                             input logic [2:0] sz);
    if (!le) return d;
    case (sz)
      3'd1: return mirror(d, 0, 2);
      3'd2: return mirror(d, 0, 4);
      3'd3: return mirror(d, 0, 8);
      3'd4: return mirror(mirror(d, 0, 4), 4, 4);
      default: return d;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [1:0] kind, input logic [2:0] sz,
                      input logic [2:0] tl, input logic cle, input logic priv,
                      input logic isel, input logic [7:0] imm, input logic [7:0] areg,
                      input logic [63:0] st, input logic [63:0] ld);
    exp_t e;
    logic [7:0] a;
    @(negedge clk);
    i_vld = 1'b1; i_kind = kind; i_size = sz; i_tl = tl; i_cle = cle;
    i_priv = priv; i_imm_sel = isel; i_imm_asi = imm; i_asi_reg = areg;
    i_st_data = st; i_ld_data = ld;
    e.fault = 1'b0; e.nop = 1'b0;
    if (kind == 2'd0) begin
      e.asi = (tl == 0) ? 8'h80 : 8'h04;
      e.le  = 1'b0;
    end else if (kind == 2'd1) begin
      if (tl == 0) e.asi = cle ? 8'h88 : 8'h80;
      else         e.asi = cle ? 8'h0C : 8'h04;
      e.le = cle;
    end else begin
      a = isel ? areg : imm;
      e.asi = a;
      e.le  = a[3];
      if (!priv && a < 8'h80) begin
        if (kind == 2'd3) e.nop = 1'b1;
        else              e.fault = 1'b1;
      end
    end
    e.st = model_data(st, e.le, sz);
    e.ld = model_data(ld, e.le, sz);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      i_vld = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (o_vld) begin
        if (expq.size() == 0) begin
          check("R9", "unexpected o_vld", 64'(o_vld), 64'd0);
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, "asi",   64'(o_asi),   64'(e.asi));
          check(t, "le",    64'(o_le),    64'(e.le));
          check(t, "fault", 64'(o_fault), 64'(e.fault));
          check(t, "nop",   64'(o_nop),   64'(e.nop));
          check(t, "st",    o_st_data,    e.st);
          check(t, "ld",    o_ld_data,    e.ld);
        end
      end
    end
  end

  localparam logic [63:0] PAT_A = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PAT_B = 64'hF0E1_D2C3_B4A5_9687;

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "o_vld in reset",   64'(o_vld),   64'd0);
    check("R10", "o_fault in reset", 64'(o_fault), 64'd0);
    check("R10", "o_nop in reset",   64'(o_nop),   64'd0);
    rst_n = 1'b1;
    idle(2);
    check("R9", "o_vld idle", 64'(o_vld), 64'd0);

    // R1 fetches, mode bit set but ignored
    send("R1", 2'd0, 3'd3, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R1", 2'd0, 3'd2, 3'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, PAT_B, PAT_A);
    idle(1);
    // R2 / R3 normal data
    send("R2", 2'd1, 3'd3, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R2", 2'd1, 3'd3, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R3", 2'd1, 3'd2, 3'd1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R3", 2'd1, 3'd2, 3'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    idle(2);
    // R4 / R5 alternate space
    send("R4", 2'd2, 3'd3, 3'd0, 1'b0, 1'b1, 1'b0, 8'h88, 8'h04, PAT_A, PAT_B);
    send("R4", 2'd2, 3'd1, 3'd0, 1'b0, 1'b1, 1'b1, 8'h80, 8'h0C, PAT_B, PAT_A);
    send("R5", 2'd2, 3'd2, 3'd0, 1'b1, 1'b0, 1'b1, 8'h80, 8'h7F, PAT_A, PAT_B);
    send("R5", 2'd2, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, PAT_A, PAT_B);
    send("R5", 2'd1, 3'd2, 3'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    // R6 prefetch-alternate
    send("R6", 2'd3, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h10, 8'h00, PAT_A, PAT_B);
    send("R6", 2'd3, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h81, PAT_A, PAT_B);
    idle(1);
    // R7 sizes, little and big
    send("R7", 2'd1, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R7", 2'd1, 3'd1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R7", 2'd1, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R7", 2'd2, 3'd3, 3'd0, 1'b0, 1'b1, 1'b0, 8'h04, 8'h00, PAT_B, PAT_A);
    // R8 pair
    send("R8", 2'd1, 3'd4, 3'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    send("R8", 2'd2, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h88, PAT_B, PAT_A);
    send("R8", 2'd1, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, PAT_A, PAT_B);
    idle(4);
    check("R9", "queue drained", 64'(expq.size()), 64'd0);
    check("R9", "o_vld after idle", 64'(o_vld), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule